// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the 32-bit datapath of a small multicycle processor. Each instruction is split into short register transfers, one per clock: fetch into the instruction register, operand read into two operand latches and an equality latch, one ALU step into a result latch, an optional data-memory read into a load latch, and a final write-back together with the program-counter update. The datapath holds a program counter, an instruction register, a 32-entry register file and five staging registers. Every storage element has its own load enable.

The block makes no decisions of its own. Each enable, the ALU function, the second-operand source, the immediate extension mode, the write-back destination and source, both data-memory strobes and the branch select arrive as inputs from an external sequencer. The block returns the opcode and function fields of the held instruction and the stored equality flag, and the sequencer uses these to choose its next state. Instruction memory is read at the program counter. Data memory is addressed by the result latch and written from the second operand latch. Both memories return read data in the same cycle as the address.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register, every staging register and every register-file entry to zero. The instruction-memory address port always shows the program counter.
- R2: The instruction register loads the instruction-memory word when `ir_en` is high and holds its value otherwise. `opcode` shows instruction bits [31:26] and `funct` shows bits [5:0]. Within the instruction, rs is bits [25:21], rt is [20:16], rd is [15:11] and the immediate is [15:0].
- R3: When `a_en` is high, operand latch A loads R[rs]. When `b_en` is high, operand latch B loads R[rt]. Each latch holds its value when its own enable is low. B is visible on `dmem_wdata`.
- R4: When `e_en` is high, the equality latch loads 1 if R[rs] equals R[rt] and 0 otherwise. `eq_flag` shows the latch.
- R5: When `s_en` is high, the result latch loads the ALU output. `alu_op` selects the function: 000 add, 001 subtract (A minus operand), 010 AND, 011 OR, 100 signed set-less-than (result 1 or 0). Any other code gives zero. The second ALU operand is B when `alu_src` is 0 and the extended immediate when it is 1. The result latch is visible on `dmem_addr`.
- R6: When `ext_sign` is 1, the 16-bit immediate is sign-extended. When it is 0, the immediate is zero-extended.
- R7: When `rf_we` is high, the register file is written on the clock edge. The destination is rd when `dst_rd` is 1 and rt when it is 0. The data is the load latch M when `wb_mem` is 1 and the result latch S when it is 0.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: `dmem_we` follows `mem_wr` and `dmem_re` follows `mem_rd`. When `m_en` is high, the load latch M captures `dmem_rdata`.
- R10: When `pc_en` is high, the program counter becomes PC+4. If `pc_branch` is also high and the equality latch is 1, it becomes PC+4 plus the sign-extended immediate shifted left by two, whatever `ext_sign` is. When `pc_en` is low, the program counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_en | input | 1 | Instruction register load |
| a_en | input | 1 | Operand latch A load |
| b_en | input | 1 | Operand latch B load |
| e_en | input | 1 | Equality latch load |
| s_en | input | 1 | Result latch load |
| m_en | input | 1 | Load latch load |
| pc_en | input | 1 | Program counter update |
| rf_we | input | 1 | Register file write |
| alu_op | input | 3 | ALU function code |
| alu_src | input | 1 | Second ALU operand: 0 = B, 1 = immediate |
| ext_sign | input | 1 | 1 = sign-extend, 0 = zero-extend |
| dst_rd | input | 1 | Write-back destination: 1 = rd, 0 = rt |
| wb_mem | input | 1 | Write-back source: 1 = M, 0 = S |
| mem_rd | input | 1 | Data-memory read strobe |
| mem_wr | input | 1 | Data-memory write strobe |
| pc_branch | input | 1 | Branch select for the next PC |
| imem_addr | output | 32 | Instruction-memory address (program counter) |
| imem_data | input | 32 | Instruction-memory read data |
| dmem_addr | output | 32 | Data-memory address (result latch) |
| dmem_wdata | output | 32 | Data-memory write data (operand latch B) |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_re | output | 1 | Data-memory read strobe |
| dmem_rdata | input | 32 | Data-memory read data |
| opcode | output | 6 | Opcode field of the held instruction |
| funct | output | 6 | Function field of the held instruction |
| eq_flag | output | 1 | Stored equality flag |

## Verification
The result latch drives the data address and operand latch B drives the write data, so a wrong ALU result or a wrong operand shows on the pins in the cycle after its enable. A wrong register-file entry shows one decode later, on `dmem_wdata` or `eq_flag`. A missed write-back, a write to the wrong destination or a write that reaches register 0 shows only when a later instruction reads that register, and the scoreboard catches it at the next store of that register. A wrong branch target or a PC that fails to hold shows on `imem_addr` in the cycle after the update.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
   typedef enum logic [2:0] {
      ALU_ADD = 3'b000,
      ALU_SUB = 3'b001,
      ALU_AND = 3'b010,
      ALU_OR  = 3'b011,
      ALU_SLT = 3'b100
   } alu_op_e;

   localparam int OPC_HI = 31;
   localparam int OPC_LO = 26;
   localparam int RS_LO  = 21;
   localparam int RT_LO  = 16;
   localparam int RD_LO  = 11;
   localparam int IMM_W  = 16;
   localparam int FN_W   = 6;
   localparam int FLD_W  = 5;
endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
   parameter int W         = 32,
   parameter int N         = 32,
   parameter bit HARD_ZERO = 1'b1,
   localparam int AW       = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd2
);
   logic [W-1:0] row [N];

   if (N < 2 || (1 << AW) != N) begin : g_bad_depth
      $error("mc_regfile: depth must be a power of two of at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      if (i == 0 && HARD_ZERO) begin : g_zero
         assign row[i] = '0;
      end else begin : g_live
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && wa == AW'(i))
               q <= wd;
         end
         assign row[i] = q;
      end
   end

   assign rd1 = row[ra1];
   assign rd2 = row[ra2];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
   import mc_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic lt;

   if (SLT_SIGNED) begin : g_lt_signed
      assign lt = $signed(a) < $signed(b);
   end else begin : g_lt_unsigned
      assign lt = a < b;
   end

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/mc_imm_ext.sv
`timescale 1ns/1ps
module mc_imm_ext
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             sign_mode,
   output logic [W-1:0]     ext,
   output logic [W-1:0]     br_off
);
   logic [W-1:0] sx;

   if (W < IMM_W + 2) begin : g_bad_width
      $error("mc_imm_ext: width too small for the immediate");
   end

   assign sx     = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
   assign ext    = sign_mode ? sx : {{(W-IMM_W){1'b0}}, imm};
   assign br_off = {sx[W-3:0], 2'b00};
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
   import mc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int REG_COUNT  = 32,
   parameter bit SLT_SIGNED = 1'b1,
   localparam int RA_W      = $clog2(REG_COUNT)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ir_en,
   input  logic            a_en,
   input  logic            b_en,
   input  logic            e_en,
   input  logic            s_en,
   input  logic            m_en,
   input  logic            pc_en,
   input  logic            rf_we,
   input  logic [2:0]      alu_op,
   input  logic            alu_src,
   input  logic            ext_sign,
   input  logic            dst_rd,
   input  logic            wb_mem,
   input  logic            mem_rd,
   input  logic            mem_wr,
   input  logic            pc_branch,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   output logic            dmem_re,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic [5:0]      opcode,
   output logic [5:0]      funct
   ,
   output logic            eq_flag
);
   if (XLEN < 32) begin : g_bad_xlen
      $error("mc_datapath: data width below 32");
   end
   if (REG_COUNT > 32) begin : g_bad_regs
      $error("mc_datapath: register fields address at most 32 entries");
   end

   logic [XLEN-1:0] pc_q, a_q, b_q, s_q, m_q;
   logic [31:0]     ir_q;
   logic            e_q;

   logic [XLEN-1:0] rs_val, rt_val, ext_val, br_off, alu_b, alu_y, wb_data, pc_seq, pc_next;
   logic [RA_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;

   assign rs_idx = ir_q[RS_LO +: RA_W];
   assign rt_idx = ir_q[RT_LO +: RA_W];
   assign rd_idx = ir_q[RD_LO +: RA_W];

   mc_regfile #(.W(XLEN), .N(REG_COUNT), .HARD_ZERO(1'b1)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (rf_we),
      .wa  (wr_idx),
      .wd  (wb_data),
      .ra1 (rs_idx),
      .rd1 (rs_val),
      .ra2 (rt_idx),
      .rd2 (rt_val)
   );

   mc_imm_ext #(.W(XLEN)) u_ext (
      .imm       (ir_q[IMM_W-1:0]),
      .sign_mode (ext_sign),
      .ext       (ext_val),
      .br_off    (br_off)
   );

   assign alu_b = alu_src ? ext_val : b_q;

   mc_alu #(.W(XLEN), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .op (alu_op_e'(alu_op)),
      .a  (a_q),
      .b  (alu_b),
      .y  (alu_y)
   );

   assign wr_idx  = dst_rd ? rd_idx : rt_idx;
   assign wb_data = wb_mem ? m_q : s_q;
   assign pc_seq  = pc_q + XLEN'(4);
   assign pc_next = (pc_branch && e_q) ? pc_seq + br_off : pc_seq;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
         ir_q <= '0;
         a_q  <= '0;
         b_q  <= '0;
         e_q  <= 1'b0;
         s_q  <= '0;
         m_q  <= '0;
      end else begin
         if (pc_en) pc_q <= pc_next;
         if (ir_en) ir_q <= imem_data;
         if (a_en)  a_q  <= rs_val;
         if (b_en)  b_q  <= rt_val;
         if (e_en)  e_q  <= (rs_val == rt_val);
         if (s_en)  s_q  <= alu_y;
         if (m_en)  m_q  <= dmem_rdata;
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = s_q;
   assign dmem_wdata = b_q;
   assign dmem_we    = mem_wr;
   assign dmem_re    = mem_rd;
   assign opcode     = ir_q[OPC_HI:OPC_LO];
   assign funct      = ir_q[FN_W-1:0];
   assign eq_flag    = e_q;

   a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == '0));
   a_r2_ir_hold:  assert property (@(posedge clk) disable iff (rst) !ir_en |=> $stable(ir_q));
   a_r3_a_hold:   assert property (@(posedge clk) disable iff (rst) !a_en |=> $stable(a_q));
   a_r4_e_hold:   assert property (@(posedge clk) disable iff (rst) !e_en |=> $stable(e_q));
   a_r9_m_hold:   assert property (@(posedge clk) disable iff (rst) !m_en |=> $stable(m_q));
   a_r10_pc_hold: assert property (@(posedge clk) disable iff (rst) !pc_en |=> $stable(pc_q));
   a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
                     (pc_en && !(pc_branch && e_q)) |=> (pc_q == $past(pc_q) + XLEN'(4)));
endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb;
   logic clk = 1'b0;
   logic rst;
   logic ir_en, a_en, b_en, e_en, s_en, m_en, pc_en, rf_we;
   logic [2:0] alu_op;
   logic alu_src, ext_sign, dst_rd, wb_mem, mem_rd, mem_wr, pc_branch;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic dmem_we, dmem_re, eq_flag;
   logic [5:0] opcode, funct;

   always #2 clk = ~clk;

   mc_datapath u_dut (
      .clk(clk), .rst(rst), .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .e_en(e_en),
      .s_en(s_en), .m_en(m_en), .pc_en(pc_en), .rf_we(rf_we), .alu_op(alu_op),
      .alu_src(alu_src), .ext_sign(ext_sign), .dst_rd(dst_rd), .wb_mem(wb_mem),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_branch(pc_branch),
      .imem_addr(imem_addr), .imem_data(imem_data), .dmem_addr(dmem_addr),
      .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
      .dmem_rdata(dmem_rdata), .opcode(opcode), .funct(funct), .eq_flag(eq_flag)
   );

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   assign imem_data  = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   logic [63:0] exp_q [$];
   logic [31:0] rf [32];
   logic [31:0] pc;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // scoreboard monitor: each store must match the oldest expected (address, data)
   always begin
      @(posedge clk);
      #1;
      if (!rst && dmem_we) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R9 unexpected store: actual=%h expected=none", dmem_addr);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            if ({dmem_addr, dmem_wdata} !== e) begin
               n_err++;
               $display("FAIL R7/R9 store: actual=%h expected=%h", {dmem_addr, dmem_wdata}, e);
            end
         end
      end
   end

   task automatic clr();
      {ir_en, a_en, b_en, e_en, s_en, m_en, pc_en, rf_we} = '0;
      alu_op = 3'b000;
      {alu_src, ext_sign, dst_rd, wb_mem, mem_rd, mem_wr, pc_branch} = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      clr();
   endtask

   function automatic logic [31:0] rtyp(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] ityp(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
      return {op, 5'(rs), 5'(rt), im};
   endfunction
   function automatic logic [31:0] sx(input logic [15:0] i);
      return {{16{i[15]}}, i};
   endfunction
   function automatic logic [2:0] fn_code(input logic [5:0] fn);
      case (fn)
         6'h21: return 3'b000;
         6'h23: return 3'b001;
         6'h24: return 3'b010;
         6'h25: return 3'b011;
         default: return 3'b100;
      endcase
   endfunction
   function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'b000: return a + b;
         3'b001: return a - b;
         3'b010: return a & b;
         3'b011: return a | b;
         3'b100: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   // bench-side sequencer: one instruction through its register transfers
   task automatic exec();
      logic [31:0] ins, ta, tb, res;
      logic [5:0] op, fn;
      int rs, rt, rd;
      ins = imem[pc[7:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      chk("R1 fetch address", imem_addr, pc);
      ir_en = 1'b1; tick();
      chk("R2 opcode", 32'(opcode), 32'(op));
      chk("R2 funct", 32'(funct), 32'(fn));
      a_en = 1'b1; b_en = 1'b1; e_en = 1'b1; tick();
      ta = rf[rs]; tb = rf[rt];
      chk("R4 equality", 32'(eq_flag), 32'(ta == tb));
      chk(rt == 0 ? "R8 reg0 read" : "R3 operand B", dmem_wdata, tb);
      case (op)
         6'h00: begin
            alu_op = fn_code(fn); s_en = 1'b1; tick();
            res = alu_ref(fn_code(fn), ta, tb);
            chk("R5 alu result", dmem_addr, res);
            rf_we = 1'b1; dst_rd = 1'b1; pc_en = 1'b1; tick();
            if (rd != 0) rf[rd] = res;
         end
         6'h0d: begin
            alu_op = 3'b011; alu_src = 1'b1; s_en = 1'b1; tick();
            res = ta | {16'd0, ins[15:0]};
            chk("R6 zero extend", dmem_addr, res);
            rf_we = 1'b1; pc_en = 1'b1; tick();
            if (rt != 0) rf[rt] = res;
         end
         6'h23: begin
            alu_src = 1'b1; ext_sign = 1'b1; s_en = 1'b1; tick();
            res = ta + sx(ins[15:0]);
            chk("R6 sign extend", dmem_addr, res);
            mem_rd = 1'b1; m_en = 1'b1;
            #1 chk("R9 read strobe", 32'(dmem_re), 32'd1);
            tick();
            rf_we = 1'b1; wb_mem = 1'b1; pc_en = 1'b1; tick();
            if (rt != 0) rf[rt] = dmem[res[7:2]];
         end
         6'h2b: begin
            alu_src = 1'b1; ext_sign = 1'b1; s_en = 1'b1; tick();
            res = ta + sx(ins[15:0]);
            chk("R6 store address", dmem_addr, res);
            exp_q.push_back({res, tb});
            mem_wr = 1'b1; pc_en = 1'b1; tick();
         end
         default: begin
            pc_en = 1'b1; pc_branch = 1'b1; tick();
            if (ta == tb) pc = pc + sx(ins[15:0]) * 4;
         end
      endcase
      pc = pc + 4;
      chk("R10 next pc", imem_addr, pc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
      for (int i = 0; i < 32; i++) rf[i] = '0;
      dmem[0] = 32'hCAFE_F00D;
      imem[0]  = ityp(6'h0d, 0, 1, 16'h0007);
      imem[1]  = ityp(6'h0d, 0, 2, 16'hFFFC);
      imem[2]  = rtyp(0, 1, 3, 6'h23);
      imem[3]  = rtyp(3, 1, 4, 6'h2a);
      imem[4]  = rtyp(1, 2, 5, 6'h21);
      imem[5]  = rtyp(2, 1, 6, 6'h24);
      imem[6]  = ityp(6'h2b, 0, 5, 16'd8);
      imem[7]  = ityp(6'h23, 6, 7, 16'hFFFC);
      imem[8]  = ityp(6'h2b, 0, 7, 16'd12);
      imem[9]  = ityp(6'h0d, 0, 0, 16'h0055);   // R8: write to register 0
      imem[10] = ityp(6'h2b, 0, 0, 16'd16);     // R8: stores zero
      imem[11] = ityp(6'h04, 1, 3, 16'd5);      // not taken
      imem[12] = ityp(6'h04, 4, 4, 16'd1);      // taken, skips 13
      imem[13] = ityp(6'h0d, 0, 8, 16'h0099);
      imem[14] = ityp(6'h2b, 0, 4, 16'd20);
      imem[15] = rtyp(1, 2, 9, 6'h25);
      imem[16] = ityp(6'h2b, 0, 9, 16'd24);
      clr();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset pc", imem_addr, 32'd0);
      chk("R1 reset opcode", 32'(opcode), 32'd0);
      chk("R1 reset equality", 32'(eq_flag), 32'd0);
      chk("R1 reset result latch", dmem_addr, 32'd0);
      pc = 32'd0;
      for (int n = 0; n < 40 && pc < 32'd68; n++) exec();
      chk("R10 program end", imem_addr, 32'd68);

      tick();
      chk("R10 pc hold", imem_addr, 32'd68);
      imem[17] = rtyp(1, 5, 10, 6'h21);
      ir_en = 1'b1; tick();
      chk("R2 load", 32'(funct), 32'h21);
      imem[17] = ityp(6'h0d, 0, 0, 16'h0000);
      imem[17][31:26] = 6'h3f;
      tick();
      chk("R2 hold without enable", 32'(opcode), 32'd0);
      a_en = 1'b1; tick();
      chk("R3 B holds while A loads", dmem_wdata, 32'h0000_FFFF);
      s_en = 1'b1; tick();
      chk("R3 A loaded alone", dmem_addr, 32'd7 + 32'h0000_FFFF);
      b_en = 1'b1; tick();
      chk("R3 B loaded alone", dmem_wdata, 32'h0001_0003);
      s_en = 1'b1; tick();
      chk("R5 add after B load", dmem_addr, 32'h0001_000A);
      alu_op = 3'b101; s_en = 1'b1; tick();
      chk("R5 unused code gives zero", dmem_addr, 32'd0);
      alu_op = 3'b001; s_en = 1'b1; tick();
      chk("R5 subtract", dmem_addr, 32'd7 - 32'h0001_0003);
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R1 mid-run reset pc", imem_addr, 32'd0);
      chk("R1 mid-run reset opcode", 32'(opcode), 32'd0);
      tick();
      chk("R9 all stores seen", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      report();
   end
endmodule